// File: doc/BRIEF.md
# Parallel Port Extended-Capabilities Host Transfer Engine

This block is the host end of a loosely coupled, byte-wide parallel link. Software-side logic queues bytes into a small transmit FIFO, each tagged as data or command. A forward engine sends them to the peripheral with an interlocked strobe and acknowledge handshake. A separate flag line tells the peripheral whether the byte is data or a command. A command byte uses its top bit to choose its meaning: top bit 0 carries a run length, top bit 1 carries a channel number. Each byte counts as sent only when the host strobe returns high. An abort before that point leaves the byte queued and the counter unchanged.

The link runs in one direction at a time. A change to the reverse direction must be requested explicitly. The host releases the data bus, lowers its turnaround request and waits for the peripheral to acknowledge. Once reversed, the peripheral strobes bytes in. The host acknowledges each byte with its flag line and sorts it: data and run-length commands go into a receive FIFO, and channel commands update a channel register. A 3-bit mode register enables the protocol engine only when it holds the value 011.

Top module: `ecp_host_engine`

## Requirements
- R1: After reset: mode 000, `link_on_o` 0, `h_strobe_o` 1, `turn_req_n_o` 1, `pd_oe_o` 1, `busy_o` 0, `sent_count_o` 0, `rx_empty_o` 1, `tx_full_o` 0, `peer_has_data_o` 0.
- R2: `link_on_o` is 1 exactly when the mode register holds 011. In any other mode, queued bytes are not sent and `h_strobe_o` stays high.
- R3: A queued data byte is sent as follows. `pd_o` carries the byte and `h_flag_o` is 1 while `h_strobe_o` is low.
- R4: A queued command byte is sent with `h_flag_o` at 0 while `h_strobe_o` is low. Its bits go out unchanged.
- R5: `sent_count_o` rises by one in the same cycle that `h_strobe_o` returns high after the peripheral has raised `p_busy_i`. It never changes at any other time.
- R6: An `abort_i` pulse while `h_strobe_o` is low has these effects: `h_strobe_o` goes high, the mode becomes 000 and `link_on_o` goes to 0, and `sent_count_o` is unchanged. The byte stays queued and is the next byte sent once mode 011 is restored.
- R7: `h_strobe_o` stays low for as long as `p_busy_i` stays low. The next byte does not start until `p_busy_i` has returned low.
- R8: A reverse request (`rev_req_i`) is ignored while the transmit FIFO holds bytes or a forward byte is in flight. `busy_o` is 1 in that state.
- R9: An accepted reverse request drives `turn_req_n_o` low and `pd_oe_o` low. No reverse byte is acknowledged until `turn_ack_n_i` is low.
- R10: In the reverse direction, `p_strobe_i` low causes `h_flag_o` to rise and the `pd_i` byte to be captured. `h_flag_o` falls after `p_strobe_i` returns high. A byte sent with `p_busy_i` at 1 is data; a byte sent with `p_busy_i` at 0 is a command (`rx_is_cmd_o` = 1).
- R11: A reverse command byte with bit 7 = 1 loads bits 6:0 into `rx_chan_o` and is not queued. A reverse command byte with bit 7 = 0 is queued as a command (a run length).
- R12: A mode write is ignored unless the link faces forward and no forward byte is in flight.
- R13: `fwd_req_i` in the reverse direction raises `turn_req_n_o`. `pd_oe_o` returns to 1 only after `turn_ack_n_i` is high.
- R14: `peer_has_data_o` is 1 while `p_attn_n_i` is low, after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_val_i | input | 3 | Mode value to write (011 enables the protocol) |
| mode_o | output | 3 | Current mode register |
| abort_i | input | 1 | Abort the current forward byte and leave the protocol mode |
| tx_push_i | input | 1 | Queue one byte for sending |
| tx_is_cmd_i | input | 1 | Queued byte is a command |
| tx_byte_i | input | 8 | Byte to queue |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_pop_i | input | 1 | Remove the head of the receive FIFO |
| rx_byte_o | output | 8 | Head byte of the receive FIFO |
| rx_is_cmd_o | output | 1 | Head byte was a command |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_chan_o | output | 7 | Last channel number received |
| rev_req_i | input | 1 | Request a turn to the reverse direction |
| fwd_req_i | input | 1 | Request a turn back to the forward direction |
| busy_o | output | 1 | Direction change not possible now |
| sent_count_o | output | CNT_W | Forward bytes completed |
| h_strobe_o | output | 1 | Host byte strobe, active low |
| h_flag_o | output | 1 | Forward: 1 for data, 0 for command. Reverse: byte acknowledge |
| link_on_o | output | 1 | Protocol mode active |
| turn_req_n_o | output | 1 | Reverse-direction request, active low |
| pd_o | output | 8 | Data bus driven by the host |
| pd_oe_o | output | 1 | Host drives the data bus |
| pd_i | input | 8 | Data bus from the peripheral |
| p_busy_i | input | 1 | Peripheral acknowledge (forward), data/command flag (reverse) |
| p_strobe_i | input | 1 | Peripheral byte strobe, active low |
| turn_ack_n_i | input | 1 | Peripheral acknowledge of the reverse request, active low |
| p_attn_n_i | input | 1 | Peripheral has reverse data, active low |
| peer_has_data_o | output | 1 | Synchronized peripheral attention |

## Verification
The forward path is tried with three kinds of byte: a plain data byte, a channel command with its top bit set and a run-length command with it clear. Mixing them shows whether the flag line tracks each byte's tag rather than a stale value. A peripheral model that stalls its acknowledge for many cycles tells an interlocked engine apart from one that sends on a fixed timer. An abort placed mid-strobe shows whether the counter and queue respect the commit point. On the reverse side, the sequence is a data byte, a channel command and a run-length command, plus a strobe asserted before the turnaround acknowledge. This separates correct sorting into the channel register and the FIFO, and shows whether bytes are taken before the direction change is complete.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] MODE_STD  = 3'b000;
  localparam logic [2:0] MODE_BYTE = 3'b001;
  localparam logic [2:0] MODE_ECP  = 3'b011;

  typedef enum logic [1:0] {D_FWD, D_TURN_R, D_REV, D_TURN_F} dir_t;
  typedef enum logic [1:0] {F_IDLE, F_SETUP, F_STROBE, F_REL} fwd_st_t;
  typedef enum logic {R_IDLE, R_HOLD} rev_st_t;

  typedef struct packed {
    logic              is_cmd;
    logic [BYTE_W-1:0] b;
  } xword_t;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= INIT;
        else     st[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= INIT;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/ecp_fifo.sv
module ecp_fifo #(
  parameter int W = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/ecp_fwd_xfer.sv
module ecp_fwd_xfer
  import ecp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              abort,
  input  xword_t            head,
  input  logic              q_empty,
  input  logic              p_ack_s,
  output logic              pop,
  output logic              strobe_o,
  output logic              flag_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              idle_o,
  output logic [CNT_W-1:0]  count_o
);
  fwd_st_t st;

  assign pop    = (st == F_STROBE) && p_ack_s && !abort;
  assign idle_o = (st == F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= F_IDLE;
      strobe_o <= 1'b1;
      flag_o   <= 1'b1;
      data_o   <= '0;
      count_o  <= '0;
    end else if (abort) begin
      st       <= F_IDLE;
      strobe_o <= 1'b1;
    end else begin
      case (st)
        F_IDLE: if (en && !q_empty) begin
          data_o <= head.b;
          flag_o <= ~head.is_cmd;
          st     <= F_SETUP;
        end
        F_SETUP: begin
          strobe_o <= 1'b0;
          st       <= F_STROBE;
        end
        F_STROBE: if (p_ack_s) begin
          strobe_o <= 1'b1;
          count_o  <= count_o + 1'b1;
          st       <= F_REL;
        end
        F_REL: if (!p_ack_s) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecp_rev_xfer.sv
module ecp_rev_xfer
  import ecp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              p_strobe_s,
  input  logic              p_ack_s,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              q_full,
  output logic              push,
  output xword_t            push_word,
  output logic              flag_o,
  output logic [BYTE_W-2:0] chan_o,
  output logic              idle_o
);
  rev_st_t st;
  logic    take, is_cmd, is_chan;

  assign is_cmd    = ~p_ack_s;
  assign is_chan   = is_cmd && data_i[BYTE_W-1];
  assign take      = (st == R_IDLE) && en && !p_strobe_s && !q_full;
  assign push      = take && !is_chan;
  assign push_word = '{is_cmd: is_cmd, b: data_i};
  assign idle_o    = (st == R_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= R_IDLE;
      flag_o <= 1'b0;
      chan_o <= '0;
    end else if (!en) begin
      st     <= R_IDLE;
      flag_o <= 1'b0;
    end else begin
      case (st)
        R_IDLE: if (take) begin
          flag_o <= 1'b1;
          st     <= R_HOLD;
          if (is_chan) chan_o <= data_i[BYTE_W-2:0];
        end
        R_HOLD: if (p_strobe_s) begin
          flag_o <= 1'b0;
          st     <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecp_host_engine.sv
module ecp_host_engine
  import ecp_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr_i,
  input  logic [2:0]        mode_val_i,
  output logic [2:0]        mode_o,
  input  logic              abort_i,
  input  logic              tx_push_i,
  input  logic              tx_is_cmd_i,
  input  logic [7:0]        tx_byte_i,
  output logic              tx_full_o,
  input  logic              rx_pop_i,
  output logic [7:0]        rx_byte_o,
  output logic              rx_is_cmd_o,
  output logic              rx_empty_o,
  output logic [6:0]        rx_chan_o,
  input  logic              rev_req_i,
  input  logic              fwd_req_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  sent_count_o,
  output logic              h_strobe_o,
  output logic              h_flag_o,
  output logic              link_on_o,
  output logic              turn_req_n_o,
  output logic [7:0]        pd_o,
  output logic              pd_oe_o,
  input  logic [7:0]        pd_i,
  input  logic              p_busy_i,
  input  logic              p_strobe_i,
  input  logic              turn_ack_n_i,
  input  logic              p_attn_n_i,
  output logic              peer_has_data_o
);
  localparam int WORD_W = $bits(xword_t);
  localparam int NSYNC  = 4;

  dir_t   dir;
  logic   tx_empty, rx_full, tx_pop, rx_push;
  xword_t tx_head, rx_head, tx_in, rx_in;
  logic   fwd_idle, rev_idle, fwd_flag, rev_flag, fwd_en, rev_en, is_ecp;
  logic   p_ack_s, p_strobe_s, ack_n_s, attn_n_s;
  logic [NSYNC-1:0] sync_out;

  ecp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .INIT(4'b1110)) u_sync (
    .clk(clk), .rst(rst),
    .din({p_attn_n_i, turn_ack_n_i, p_strobe_i, p_busy_i}),
    .dout(sync_out)
  );
  assign {attn_n_s, ack_n_s, p_strobe_s, p_ack_s} = sync_out;

  assign tx_in = '{is_cmd: tx_is_cmd_i, b: tx_byte_i};

  ecp_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push_i), .din(tx_in), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full_o)
  );

  ecp_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_in), .pop(rx_pop_i),
    .dout(rx_head), .empty(rx_empty_o), .full(rx_full)
  );
  assign rx_byte_o   = rx_head.b;
  assign rx_is_cmd_o = rx_head.is_cmd;

  assign is_ecp = (mode_o == MODE_ECP);
  assign fwd_en = is_ecp && (dir == D_FWD);
  assign rev_en = (dir == D_REV) && !abort_i;

  ecp_fwd_xfer #(.CNT_W(CNT_W)) u_fwd (
    .clk(clk), .rst(rst), .en(fwd_en), .abort(abort_i), .head(tx_head),
    .q_empty(tx_empty), .p_ack_s(p_ack_s), .pop(tx_pop),
    .strobe_o(h_strobe_o), .flag_o(fwd_flag), .data_o(pd_o),
    .idle_o(fwd_idle), .count_o(sent_count_o)
  );

  ecp_rev_xfer u_rev (
    .clk(clk), .rst(rst), .en(rev_en), .p_strobe_s(p_strobe_s),
    .p_ack_s(p_ack_s), .data_i(pd_i), .q_full(rx_full), .push(rx_push),
    .push_word(rx_in), .flag_o(rev_flag), .chan_o(rx_chan_o),
    .idle_o(rev_idle)
  );

  assign h_flag_o        = (dir == D_FWD) ? fwd_flag : rev_flag;
  assign peer_has_data_o = ~attn_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o       <= MODE_STD;
      link_on_o    <= 1'b0;
      dir          <= D_FWD;
      turn_req_n_o <= 1'b1;
      pd_oe_o      <= 1'b1;
      busy_o       <= 1'b0;
    end else begin
      busy_o <= !tx_empty || !fwd_idle || !rev_idle ||
                (dir == D_TURN_R) || (dir == D_TURN_F);
      if (abort_i) begin
        mode_o       <= MODE_STD;
        link_on_o    <= 1'b0;
        dir          <= D_FWD;
        turn_req_n_o <= 1'b1;
        pd_oe_o      <= 1'b1;
      end else begin
        if (mode_wr_i && (dir == D_FWD) && fwd_idle) begin
          mode_o    <= mode_val_i;
          link_on_o <= (mode_val_i == MODE_ECP);
        end
        case (dir)
          D_FWD: if (rev_req_i && is_ecp && tx_empty && fwd_idle) begin
            dir          <= D_TURN_R;
            turn_req_n_o <= 1'b0;
            pd_oe_o      <= 1'b0;
          end
          D_TURN_R: if (!ack_n_s) dir <= D_REV;
          D_REV: if (fwd_req_i && rev_idle) begin
            dir          <= D_TURN_F;
            turn_req_n_o <= 1'b1;
          end
          D_TURN_F: if (ack_n_s) begin
            dir     <= D_FWD;
            pd_oe_o <= 1'b1;
          end
          default: dir <= D_FWD;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecp_host_engine_chk.sv
module ecp_host_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             h_strobe_o,
  input logic             link_on_o,
  input logic [CNT_W-1:0] sent_count_o,
  input logic             turn_req_n_o,
  input logic             pd_oe_o,
  input logic             tx_empty
);
  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !link_on_o |-> h_strobe_o);

  // R5
  count_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (sent_count_o != $past(sent_count_o)) |-> $rose(h_strobe_o));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(h_strobe_o) && link_on_o) |->
      (sent_count_o == $past(sent_count_o) + CNT_W'(1)));

  // R8
  turn_needs_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(turn_req_n_o) |-> $past(tx_empty));

  // R9
  bus_off_in_turn_chk: assert property (@(posedge clk) disable iff (rst)
    !turn_req_n_o |-> !pd_oe_o);

  // R3
  strobe_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !h_strobe_o |-> (pd_oe_o && turn_req_n_o));
endmodule

bind ecp_host_engine ecp_host_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .h_strobe_o(h_strobe_o), .link_on_o(link_on_o),
  .sent_count_o(sent_count_o), .turn_req_n_o(turn_req_n_o),
  .pd_oe_o(pd_oe_o), .tx_empty(tx_empty)
);

// File: tb/ecp_host_engine_test.sv
module ecp_host_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_wr_i = 0, abort_i = 0, tx_push_i = 0, tx_is_cmd_i = 0;
  logic [2:0] mode_val_i = 0, mode_o;
  logic [7:0] tx_byte_i = 0, rx_byte_o, pd_o, pd_i = 0;
  logic tx_full_o, rx_pop_i = 0, rx_is_cmd_o, rx_empty_o;
  logic [6:0] rx_chan_o;
  logic rev_req_i = 0, fwd_req_i = 0, busy_o;
  logic [CNT_W-1:0] sent_count_o;
  logic h_strobe_o, h_flag_o, link_on_o, turn_req_n_o, pd_oe_o;
  logic p_busy_i = 0, p_strobe_i = 1, turn_ack_n_i = 1, p_attn_n_i = 1;
  logic peer_has_data_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_host_engine #(.CNT_W(CNT_W)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_strobe(logic v, string req);
    int k = 0;
    while (h_strobe_o !== v && k < 200) begin tick(1); k++; end
    chk(req, 32'(h_strobe_o), 32'(v));
  endtask

  task automatic wait_flag(logic v, string req);
    int k = 0;
    while (h_flag_o !== v && k < 200) begin tick(1); k++; end
    chk(req, 32'(h_flag_o), 32'(v));
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy_o !== 1'b0 && k < 200) begin tick(1); k++; end
  endtask

  task automatic set_mode(logic [2:0] m);
    mode_val_i = m; mode_wr_i = 1; tick(1); mode_wr_i = 0;
  endtask

  task automatic push(logic [7:0] b, logic cmd);
    tx_byte_i = b; tx_is_cmd_i = cmd; tx_push_i = 1; tick(1); tx_push_i = 0;
  endtask

  // peripheral accepts one forward byte and checks it
  task automatic accept(logic [7:0] b, logic flag, string req);
    wait_strobe(1'b0, req);
    chk(req, 32'(pd_o), 32'(b));
    chk(req, 32'(h_flag_o), 32'(flag));
    p_busy_i = 1;
    wait_strobe(1'b1, req);
    p_busy_i = 0;
  endtask

  // peripheral sends one reverse byte
  task automatic rsend(logic [7:0] b, logic is_data, string req);
    pd_i = b; p_busy_i = is_data; tick(1);
    p_strobe_i = 0;
    wait_flag(1'b1, req);
    p_strobe_i = 1;
    wait_flag(1'b0, req);
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 link", 32'(link_on_o), 0);
    chk("R1 strobe", 32'(h_strobe_o), 1);
    chk("R1 turn", 32'(turn_req_n_o), 1);
    chk("R1 oe", 32'(pd_oe_o), 1);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 count", 32'(sent_count_o), 0);
    chk("R1 rxe", 32'(rx_empty_o), 1);
    chk("R1 txf", 32'(tx_full_o), 0);
    chk("R1 peer", 32'(peer_has_data_o), 0);
  endtask

  task automatic t_mode_gate();
    set_mode(3'b001);
    chk("R2 byte mode link", 32'(link_on_o), 0);
    push(8'hA5, 0);
    tick(12);
    chk("R2 no send outside mode", 32'(h_strobe_o), 1);
    set_mode(3'b011);
    chk("R2 link on", 32'(link_on_o), 1);
    accept(8'hA5, 1'b1, "R3 data byte");
    chk("R5 count 1", 32'(sent_count_o), 1);
  endtask

  task automatic t_commands();
    push(8'h85, 1);
    push(8'h10, 1);
    push(8'h3E, 0);
    accept(8'h85, 1'b0, "R4 channel cmd");
    accept(8'h10, 1'b0, "R4 run cmd");
    accept(8'h3E, 1'b1, "R3 data after cmd");
    chk("R5 count 4", 32'(sent_count_o), 4);
  endtask

  task automatic t_interlock();
    push(8'h11, 0);
    push(8'h22, 0);
    wait_strobe(1'b0, "R7 start");
    tick(20);
    chk("R7 strobe held", 32'(h_strobe_o), 0);
    chk("R5 no early count", 32'(sent_count_o), 4);
    p_busy_i = 1;
    wait_strobe(1'b1, "R7 release");
    chk("R5 count at rise", 32'(sent_count_o), 5);
    tick(10);
    chk("R7 next waits", 32'(h_strobe_o), 1);
    p_busy_i = 0;
    accept(8'h22, 1'b1, "R7 next byte");
    chk("R5 count 6", 32'(sent_count_o), 6);
  endtask

  task automatic t_abort();
    push(8'h3C, 0);
    wait_strobe(1'b0, "R6 start");
    abort_i = 1; tick(1); abort_i = 0;
    chk("R6 strobe high", 32'(h_strobe_o), 1);
    chk("R6 mode std", 32'(mode_o), 0);
    chk("R6 link off", 32'(link_on_o), 0);
    chk("R6 count kept", 32'(sent_count_o), 6);
    set_mode(3'b011);
    accept(8'h3C, 1'b1, "R6 byte retained");
    chk("R6 count after", 32'(sent_count_o), 7);
  endtask

  task automatic t_turn();
    push(8'h44, 0);
    wait_strobe(1'b0, "R8 start");
    chk("R8 busy", 32'(busy_o), 1);
    rev_req_i = 1; tick(1); rev_req_i = 0;
    tick(4);
    chk("R8 refused", 32'(turn_req_n_o), 1);
    p_busy_i = 1;
    wait_strobe(1'b1, "R8 finish");
    p_busy_i = 0;
    wait_idle();
    rev_req_i = 1; tick(1); rev_req_i = 0;
    chk("R9 request low", 32'(turn_req_n_o), 0);
    chk("R9 bus off", 32'(pd_oe_o), 0);
    pd_i = 8'h5A; p_busy_i = 1; p_strobe_i = 0;
    tick(8);
    chk("R9 no ack before turn", 32'(h_flag_o), 0);
    turn_ack_n_i = 0;
    wait_flag(1'b1, "R9 ack after turn");
    p_strobe_i = 1;
    wait_flag(1'b0, "R10 flag falls");
    tick(1);
    chk("R10 rx nonempty", 32'(rx_empty_o), 0);
    chk("R10 rx byte", 32'(rx_byte_o), 32'h5A);
    chk("R10 rx data tag", 32'(rx_is_cmd_o), 0);
    rx_pop_i = 1; tick(1); rx_pop_i = 0;
  endtask

  task automatic t_reverse_cmds();
    rsend(8'h87, 1'b0, "R11 chan");
    chk("R11 chan reg", 32'(rx_chan_o), 7);
    chk("R11 chan not queued", 32'(rx_empty_o), 1);
    rsend(8'h22, 1'b0, "R11 run");
    chk("R11 run queued", 32'(rx_empty_o), 0);
    chk("R11 run byte", 32'(rx_byte_o), 32'h22);
    chk("R10 cmd tag", 32'(rx_is_cmd_o), 1);
    rx_pop_i = 1; tick(1); rx_pop_i = 0;
    chk("R11 chan kept", 32'(rx_chan_o), 7);
  endtask

  task automatic t_mode_lock();
    set_mode(3'b000);
    chk("R12 mode kept", 32'(mode_o), 3);
    chk("R12 link kept", 32'(link_on_o), 1);
  endtask

  task automatic t_back();
    p_busy_i = 0;
    fwd_req_i = 1; tick(1); fwd_req_i = 0;
    chk("R13 request high", 32'(turn_req_n_o), 1);
    tick(5);
    chk("R13 bus still off", 32'(pd_oe_o), 0);
    turn_ack_n_i = 1;
    tick(4);
    chk("R13 bus on", 32'(pd_oe_o), 1);
    push(8'h99, 0);
    accept(8'h99, 1'b1, "R13 forward again");
  endtask

  task automatic t_attn();
    p_attn_n_i = 0;
    tick(3);
    chk("R14 peer data", 32'(peer_has_data_o), 1);
    p_attn_n_i = 1;
    tick(3);
    chk("R14 peer clear", 32'(peer_has_data_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_mode_gate();
    t_commands();
    t_interlock();
    t_abort();
    t_turn();
    t_reverse_cmds();
    t_mode_lock();
    t_back();
    t_attn();
    tick(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule